// File: doc/BRIEF.md
# Stationary-Frame Sequence Separator

This block takes a stream of signed two-axis grid voltage samples and splits it into a positive-sequence vector and a negative-sequence vector. It does this in the stationary frame, ahead of any phase-tracking loop. Each accepted sample passes through two cancellation stages in series. A stage adds the current vector to a delayed copy of its own input. The delayed copy is turned by a fixed angle first, and the sum is halved.

The first stage looks back a quarter of the grid period and turns the old vector by 90 degrees. This removes the fundamental negative sequence and the 5th and 7th harmonics. The second stage looks back an eighth of the period and turns by 45 degrees. This removes the 11th and 13th harmonics. For a positive-sequence fundamental the cascade has unity gain and zero phase shift. That is why the negative-sequence vector is taken as the pipeline-aligned input minus the extracted positive vector.

The number of samples per grid period is a build-time parameter and must be a multiple of 8. Each delay line advances only when a sample is accepted. The filter is correct only once its deepest tap reaches real input, 3N/8 samples back, and the block raises a flag at that point.

Top module: `dsc_seq_sep`

## Requirements
- R1: After reset, outValid, settled and all four output vectors are zero.
- R2: A sample accepted at clock edge E (inValid high) produces a one-cycle outValid pulse that is visible after edge E+2. Back-to-back samples give back-to-back pulses.
- R3: The first stage gives a = (x_a[k] − x_b[k−N/4]) >>> 1 and b = (x_b[k] + x_a[k−N/4]) >>> 1. Here >>> is an arithmetic shift that rounds toward minus infinity, and the result is clamped to the data width.
- R4: The second stage takes its input s and tap d = s[k−N/8]. It forms ra = (23170·(d_a − d_b) + 16384) >>> 15 and rb = (23170·(d_a + d_b) + 16384) >>> 15. It then outputs clamp((s_a + ra) >>> 1) and clamp((s_b + rb) >>> 1) as posAlpha and posBeta.
- R5: Sample indices k count accepted samples only. Idle cycles between samples change neither the delay lines nor the stage outputs.
- R6: negAlpha = clamp(x_a[k] − posAlpha) and negBeta = clamp(x_b[k] − posBeta), both for the same sample k.
- R7: Reset clears every delay tap. Samples older than the first one after reset count as zero.
- R8: settled stays low until the output of sample index 3N/8 (0-based), rises in that output's outValid cycle, and then stays high until reset.
- R9: Between outValid pulses, the four output vectors hold their last values.
- R10: Once settled, a balanced positive-sequence sinusoid (alpha = A·cos, beta = A·sin) appears on the positive outputs within a few LSB, with the negative outputs near zero. A negative-sequence sinusoid (beta = −A·sin) appears on the negative outputs, with the positive outputs near zero.
- R11: Sums that exceed the data width clamp to the signed limits 32767 and −32768 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Accept strobe for one input sample |
| inAlpha | input | DATA_W | Alpha-axis input sample, signed |
| inBeta | input | DATA_W | Beta-axis input sample, signed |
| outValid | output | 1 | One-cycle strobe marking a new output vector pair |
| posAlpha | output | DATA_W | Positive-sequence alpha, signed |
| posBeta | output | DATA_W | Positive-sequence beta, signed |
| negAlpha | output | DATA_W | Negative-sequence alpha, signed |
| negBeta | output | DATA_W | Negative-sequence beta, signed |
| settled | output | 1 | High once the full cascade history is real input |

## Verification
The settled flag rising and an output vector being delivered happen in the same cycle. The flag changes together with the outValid that carries sample index 3N/8. This is provoked by feeding exactly 3N/8 samples and checking that the flag is still low, then feeding one more and checking that the flag is high after that sample's output pulse. In a back-to-back stream, acceptance of a new sample also falls in the same cycle as the second stage consuming the previous one. A bit-accurate model in the bench checks every output against streams with and without idle gaps.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  // Load strobes from control to datapath, one per pipeline stage
  typedef struct packed {
    logic take;    // input sample accepted, first stage loads
    logic s1Load;  // second stage loads
    logic s2Load;  // output registers load
  } dscStrobe_t;

  // 1/sqrt(2) in signed Q1.15
  localparam logic signed [15:0] INV_SQRT2_Q15 = 16'sd23170;
  // half LSB of Q15 for round-to-nearest
  localparam int Q15_ROUND = 16384;

endpackage

// File: rtl/dsc_delay.sv
module dsc_delay #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr;

  // the slot about to be overwritten holds the word written DEPTH loads ago
  assign rdData = mem[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ptr <= '0;
    end else if (en) begin
      mem[ptr] <= wrData;
      ptr      <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/dsc_stage.sv
module dsc_stage
  import dsc_pkg::*;
#(
  parameter int DW  = 16,
  parameter int N   = 64,
  parameter int DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] inA,
  input  logic signed [DW-1:0] inB,
  output logic signed [DW-1:0] outA,
  output logic signed [DW-1:0] outB
);
  localparam int DEPTH = N / DIV;
  localparam int WW    = DW + 3;
  localparam int PW    = WW + 16;
  localparam logic signed [WW-1:0] HI = WW'((2 ** (DW - 1)) - 1);
  localparam logic signed [WW-1:0] LO = ~HI;

  logic [2*DW-1:0]       tapWord;
  logic signed [DW-1:0]  dA, dB;
  logic signed [WW-1:0]  rotA, rotB, sumA, sumB, halfA, halfB;

  function automatic logic signed [WW-1:0] ext(input logic signed [DW-1:0] v);
    return {{(WW - DW){v[DW-1]}}, v};
  endfunction

  function automatic logic signed [DW-1:0] clip(input logic signed [WW-1:0] v);
    if (v > HI)      return HI[DW-1:0];
    else if (v < LO) return LO[DW-1:0];
    else             return v[DW-1:0];
  endfunction

  dsc_delay #(.DEPTH(DEPTH), .W(2 * DW)) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .wrData ({inA, inB}),
    .rdData (tapWord)
  );

  assign dA = $signed(tapWord[2*DW-1:DW]);
  assign dB = $signed(tapWord[DW-1:0]);

  // rotation of the delayed vector by 2*pi/DIV
  if (DIV == 4) begin : g_quarter
    always_comb begin
      rotA = -ext(dB);
      rotB = ext(dA);
    end
  end else begin : g_eighth
    logic signed [WW-1:0] diffAB, sumAB;
    logic signed [PW-1:0] coef, prodA, prodB, rndA, rndB;
    always_comb begin
      diffAB = ext(dA) - ext(dB);
      sumAB  = ext(dA) + ext(dB);
      coef   = $signed({{(PW - 16){INV_SQRT2_Q15[15]}}, INV_SQRT2_Q15});
      prodA  = $signed({{16{diffAB[WW-1]}}, diffAB}) * coef;
      prodB  = $signed({{16{sumAB[WW-1]}}, sumAB}) * coef;
      rndA   = (prodA + PW'(Q15_ROUND)) >>> 15;
      rndB   = (prodB + PW'(Q15_ROUND)) >>> 15;
      rotA   = rndA[WW-1:0];
      rotB   = rndB[WW-1:0];
    end
  end

  always_comb begin
    sumA  = ext(inA) + rotA;
    sumB  = ext(inB) + rotB;
    halfA = sumA >>> 1;
    halfB = sumB >>> 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outA <= '0;
      outB <= '0;
    end else if (en) begin
      outA <= clip(halfA);
      outB <= clip(halfB);
    end
  end

  // R5
  stage_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(outA) && $stable(outB)));
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int N = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output dscStrobe_t strobe,
  output logic       outValid,
  output logic       settled
);
  localparam int SETTLE = (3 * N) / 8;
  localparam int CW     = $clog2(SETTLE + 1);

  logic [CW-1:0] seenCnt;
  logic          v1, v2, f1, f2;
  logic          fullHist;

  // this sample's deepest tap already reaches real input
  assign fullHist = inValid && (seenCnt == CW'(SETTLE));

  assign strobe.take   = inValid;
  assign strobe.s1Load = v1;
  assign strobe.s2Load = v2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seenCnt  <= '0;
      v1       <= 1'b0;
      v2       <= 1'b0;
      f1       <= 1'b0;
      f2       <= 1'b0;
      outValid <= 1'b0;
      settled  <= 1'b0;
    end else begin
      if (inValid && (seenCnt != CW'(SETTLE))) seenCnt <= seenCnt + 1'b1;
      v1       <= inValid;
      v2       <= v1;
      outValid <= v2;
      f1       <= fullHist;
      f2       <= f1;
      if (v2 && f2) settled <= 1'b1;
    end
  end

  // R2
  out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> ##3 outValid);

  // R8
  settled_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> settled);

  // R8
  settled_with_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> outValid);
endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int DW = 16,
  parameter int N  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dscStrobe_t           strobe,
  input  logic signed [DW-1:0] inA,
  input  logic signed [DW-1:0] inB,
  output logic signed [DW-1:0] posA,
  output logic signed [DW-1:0] posB,
  output logic signed [DW-1:0] negA,
  output logic signed [DW-1:0] negB
);
  localparam int NSTAGE = 2;
  localparam int WW     = DW + 1;
  localparam logic signed [WW-1:0] HI = WW'((2 ** (DW - 1)) - 1);
  localparam logic signed [WW-1:0] LO = ~HI;

  logic signed [DW-1:0] chainA [NSTAGE+1];
  logic signed [DW-1:0] chainB [NSTAGE+1];
  logic                 stageEn [NSTAGE];
  logic signed [DW-1:0] xA1, xB1, xA2, xB2;

  function automatic logic signed [DW-1:0] clip(input logic signed [WW-1:0] v);
    if (v > HI)      return HI[DW-1:0];
    else if (v < LO) return LO[DW-1:0];
    else             return v[DW-1:0];
  endfunction

  function automatic logic signed [WW-1:0] ext(input logic signed [DW-1:0] v);
    return {v[DW-1], v};
  endfunction

  assign chainA[0]  = inA;
  assign chainB[0]  = inB;
  assign stageEn[0] = strobe.take;
  assign stageEn[1] = strobe.s1Load;

  // stage g looks back N/(4*2^g) samples: quarter period, then eighth period
  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    dsc_stage #(.DW(DW), .N(N), .DIV(4 << g)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (stageEn[g]),
      .inA   (chainA[g]),
      .inB   (chainB[g]),
      .outA  (chainA[g+1]),
      .outB  (chainB[g+1])
    );
  end

  // raw input carried alongside the filter pipeline
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xA1 <= '0; xB1 <= '0; xA2 <= '0; xB2 <= '0;
    end else begin
      if (strobe.take)   begin xA1 <= inA; xB1 <= inB; end
      if (strobe.s1Load) begin xA2 <= xA1; xB2 <= xB1; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      posA <= '0; posB <= '0; negA <= '0; negB <= '0;
    end else if (strobe.s2Load) begin
      posA <= chainA[NSTAGE];
      posB <= chainB[NSTAGE];
      negA <= clip(ext(xA2) - ext(chainA[NSTAGE]));
      negB <= clip(ext(xB2) - ext(chainB[NSTAGE]));
    end
  end

  // R9
  output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.s2Load |=> ($stable(posA) && $stable(posB) && $stable(negA) && $stable(negB)));
endmodule

// File: rtl/dsc_seq_sep.sv
module dsc_seq_sep
  import dsc_pkg::*;
#(
  parameter int DATA_W             = 16,
  parameter int SAMPLES_PER_PERIOD = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inAlpha,
  input  logic signed [DATA_W-1:0] inBeta,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] posAlpha,
  output logic signed [DATA_W-1:0] posBeta,
  output logic signed [DATA_W-1:0] negAlpha,
  output logic signed [DATA_W-1:0] negBeta,
  output logic                     settled
);
  if (SAMPLES_PER_PERIOD % 8 != 0) begin : g_bad_period
    $error("SAMPLES_PER_PERIOD must be a multiple of 8");
  end

  dscStrobe_t strobe;

  dsc_ctrl #(.N(SAMPLES_PER_PERIOD)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid),
    .settled  (settled)
  );

  dsc_datapath #(.DW(DATA_W), .N(SAMPLES_PER_PERIOD)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .inA    (inAlpha),
    .inB    (inBeta),
    .posA   (posAlpha),
    .posB   (posBeta),
    .negA   (negAlpha),
    .negB   (negBeta)
  );
endmodule

// File: tb/sim_dsc_seq_sep.sv
module sim_dsc_seq_sep;
  localparam int CLK_PERIOD = 10;
  localparam int DW     = 16;
  localparam int N      = 64;
  localparam int D4     = N / 4;
  localparam int D8     = N / 8;
  localparam int SETTLE = 3 * N / 8;
  localparam int MAXS   = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inAlpha = '0, inBeta = '0;
  logic outValid, settled;
  logic signed [DW-1:0] posAlpha, posBeta, negAlpha, negBeta;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int xa [MAXS];
  int xb [MAXS];
  int oPA [MAXS];
  int oPB [MAXS];
  int oNA [MAXS];
  int oNB [MAXS];
  int nIn = 0;
  int outIdx = 0;
  bit haveLast = 0;
  int lastPA, lastPB, lastNA, lastNB;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dsc_seq_sep #(.DATA_W(DW), .SAMPLES_PER_PERIOD(N)) u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inAlpha(inAlpha), .inBeta(inBeta),
    .outValid(outValid), .posAlpha(posAlpha), .posBeta(posBeta),
    .negAlpha(negAlpha), .negBeta(negBeta), .settled(settled)
  );

  // ---------------- reference model built from the requirements ----------------
  function automatic int satv(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int xaAt(int k); return (k < 0) ? 0 : xa[k]; endfunction
  function automatic int xbAt(int k); return (k < 0) ? 0 : xb[k]; endfunction

  // R3 first stage
  function automatic void s1At(int k, output int oa, output int ob);
    if (k < 0) begin oa = 0; ob = 0; end
    else begin
      oa = satv((xaAt(k) - xbAt(k - D4)) >>> 1);
      ob = satv((xbAt(k) + xaAt(k - D4)) >>> 1);
    end
  endfunction

  // R4 second stage
  function automatic void posAt(int k, output int pa, output int pb);
    int sa, sb, da, db, ra, rb;
    s1At(k, sa, sb);
    s1At(k - D8, da, db);
    ra = (23170 * (da - db) + 16384) >>> 15;
    rb = (23170 * (da + db) + 16384) >>> 15;
    pa = satv((sa + ra) >>> 1);
    pb = satv((sb + rb) >>> 1);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int absv(int v); return (v < 0) ? -v : v; endfunction

  // ---------------- output monitor ----------------
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (outValid) begin
        int pa, pb;
        posAt(outIdx, pa, pb);
        // R3 R4: positive vector matches the two-stage model
        chk(int'(posAlpha) == pa, "R3 R4", "posAlpha", int'(posAlpha), pa);
        chk(int'(posBeta) == pb, "R3 R4", "posBeta", int'(posBeta), pb);
        // R6: negative vector is input minus positive
        chk(int'(negAlpha) == satv(xa[outIdx] - pa), "R6", "negAlpha", int'(negAlpha), satv(xa[outIdx] - pa));
        chk(int'(negBeta) == satv(xb[outIdx] - pb), "R6", "negBeta", int'(negBeta), satv(xb[outIdx] - pb));
        // R8: flag follows the sample index
        chk(settled == (outIdx >= SETTLE), "R8", "settled", int'(settled), int'(outIdx >= SETTLE));
        oPA[outIdx] = posAlpha; oPB[outIdx] = posBeta;
        oNA[outIdx] = negAlpha; oNB[outIdx] = negBeta;
        lastPA = posAlpha; lastPB = posBeta; lastNA = negAlpha; lastNB = negBeta;
        haveLast = 1;
        outIdx++;
      end else if (haveLast) begin
        // R9: outputs hold between pulses
        chk(int'(posAlpha) == lastPA && int'(posBeta) == lastPB &&
            int'(negAlpha) == lastNA && int'(negBeta) == lastNB,
            "R9", "hold posAlpha", int'(posAlpha), lastPA);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic doReset();
    @(negedge clk);
    inValid = 1'b0;
    rst_n = 1'b0;
    nIn = 0;
    outIdx = 0;
    haveLast = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sendSample(int a, int b);
    @(negedge clk);
    inValid = 1'b1;
    inAlpha = DW'(a);
    inBeta  = DW'(b);
    xa[nIn] = a;
    xb[nIn] = b;
    nIn++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15]));
  endfunction

  // ---------------- scenarios ----------------
  task automatic testReset();
    doReset();
    @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid", int'(outValid), 0);
    chk(settled == 1'b0, "R1", "settled", int'(settled), 0);
    chk(posAlpha == 0 && posBeta == 0, "R1", "pos", int'(posAlpha), 0);
    chk(negAlpha == 0 && negBeta == 0, "R1", "neg", int'(negAlpha), 0);
  endtask

  task automatic testLatency();
    doReset();
    sendSample(100, -50);
    @(negedge clk); inValid = 1'b0;
    chk(outValid == 1'b0, "R2", "outValid after 1 edge", int'(outValid), 0);
    @(negedge clk);
    chk(outValid == 1'b0, "R2", "outValid after 2 edges", int'(outValid), 0);
    @(negedge clk);
    chk(outValid == 1'b1, "R2", "outValid after 3 edges", int'(outValid), 1);
    @(negedge clk);
    chk(outValid == 1'b0, "R2", "outValid pulse width", int'(outValid), 0);
    // back-to-back samples give back-to-back pulses
    sendSample(1, 2);
    sendSample(3, 4);
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);
    chk(outValid == 1'b1, "R2", "first of pair", int'(outValid), 1);
    @(negedge clk);
    chk(outValid == 1'b1, "R2", "second of pair", int'(outValid), 1);
    idle(3);
  endtask

  task automatic testRandomStream();
    doReset();
    for (int i = 0; i < 120; i++) sendSample(nextRand(), nextRand());
    idle(6);
    chk(outIdx == 120, "R2", "output count", outIdx, 120);
  endtask

  task automatic testGaps();
    doReset();
    for (int i = 0; i < 60; i++) begin
      sendSample(nextRand() >>> 2, nextRand() >>> 2);
      if (i % 3 != 0) idle(i % 4 + 1);
    end
    idle(6);
    // R5: index counts accepted samples only, so every sample got one output
    chk(outIdx == 60, "R5", "output count with gaps", outIdx, 60);
  endtask

  task automatic testSettled();
    doReset();
    for (int i = 0; i < SETTLE; i++) sendSample(500 + i, -300);
    idle(6);
    chk(settled == 1'b0, "R8", "settled after 3N/8 samples", int'(settled), 0);
    sendSample(7, 7);
    idle(6);
    chk(settled == 1'b1, "R8", "settled after next sample", int'(settled), 1);
  endtask

  task automatic testHistoryCleared();
    doReset();
    for (int i = 0; i < 40; i++) sendSample(20000, -20000);
    idle(4);
    doReset();
    sendSample(1000, 2000);
    idle(5);
    // R7: zero history gives stage1 (500,1000), stage2 (250,500)
    chk(oPA[0] == 250, "R7", "posAlpha first sample", oPA[0], 250);
    chk(oPB[0] == 500, "R7", "posBeta first sample", oPB[0], 500);
    chk(oNA[0] == 750, "R7", "negAlpha first sample", oNA[0], 750);
    chk(oNB[0] == 1500, "R7", "negBeta first sample", oNB[0], 1500);
  endtask

  task automatic testSequence(bit negative);
    doReset();
    for (int i = 0; i < 4 * N; i++) begin
      real ph = 2.0 * 3.14159265358979 * real'(i) / real'(N);
      int a = int'(12000.0 * $cos(ph));
      int b = int'(12000.0 * $sin(ph));
      sendSample(a, negative ? -b : b);
    end
    idle(6);
    for (int j = 0; j < 5; j++) begin
      int k = 100 + 30 * j;
      if (!negative) begin
        chk(absv(oPA[k] - xa[k]) <= 8, "R10", "pos seq posAlpha", oPA[k], xa[k]);
        chk(absv(oPB[k] - xb[k]) <= 8, "R10", "pos seq posBeta", oPB[k], xb[k]);
        chk(absv(oNA[k]) <= 8 && absv(oNB[k]) <= 8, "R10", "pos seq negAlpha", oNA[k], 0);
      end else begin
        chk(absv(oPA[k]) <= 8 && absv(oPB[k]) <= 8, "R10", "neg seq posAlpha", oPA[k], 0);
        chk(absv(oNA[k] - xa[k]) <= 8, "R10", "neg seq negAlpha", oNA[k], xa[k]);
        chk(absv(oNB[k] - xb[k]) <= 8, "R10", "neg seq negBeta", oNB[k], xb[k]);
      end
    end
  endtask

  task automatic testSaturation();
    doReset();
    for (int i = 0; i < 40; i++) sendSample((i < 16) ? -32768 : 32767, -32768);
    idle(6);
    // R11: sample 24 sums to 39553 before clamping
    chk(oPA[24] == 32767, "R11", "posAlpha clamp", oPA[24], 32767);
    chk(oNA[24] == 0, "R11", "negAlpha after clamp", oNA[24], 0);
  endtask

  initial begin
    testReset();
    testLatency();
    testRandomStream();
    testGaps();
    testSettled();
    testHistoryCleared();
    testSequence(1'b0);
    testSequence(1'b1);
    testSaturation();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule